// File: doc/BRIEF.md
# Quad Channel Double-Buffered Register Controller

This block sits behind a serial command receiver and carries out each decoded command against four output channels. Every channel holds a staging register and an active register, both 16 bits wide, plus an enable flag. Commands can load a staging register, move it to the active register, or do both at once. One command loads a single staging register and then promotes all four channels together. Other commands put one channel or the whole chip into power-down, or choose between the internal and the external reference.

The receiver presents a command nibble, an address nibble and a 16-bit data word, and qualifies them with a one-cycle valid strobe. The block answers with the four active codes, one enable flag per channel, and a flag that turns the internal reference on. A strap input is sampled during reset and picks the start-up code: zero-scale or mid-scale. A resolution parameter lets the same block drive a 12-bit converter. In that case the unused low bits of every active code are held at zero.

Top module: `quad_dac_ctrl`

## Requirements
- R1: While `rst` is high, every staging and active register is set to 0x0000 if `por_mid_i` is low and to 0x8000 if it is high. All four channel enables go to 1 and `ref_en_o` goes to 1.
- R2: Command 0x0 loads `data_i` into the staging register of the addressed channel. No active code changes.
- R3: Command 0x1 copies the staging register of the addressed channel into its active register and sets that channel's enable.
- R4: Command 0x2 first loads `data_i` into the addressed staging register. It then copies all four staging registers into their active registers and sets all four enables.
- R5: Command 0x3 loads `data_i` into the addressed channel and makes it the active code in the same operation. It also sets that channel's enable.
- R6: Command 0x4 clears the enable of the addressed channel. Its staging and active registers keep their contents, so `code_o` stays the same.
- R7: Command 0x5 clears all four enables and `ref_en_o`. No register contents change.
- R8: Command 0x6 sets `ref_en_o`, and command 0x7 clears it.
- R9: Command 0xF (no-op) and the reserved commands 0x8 to 0xE change no output and no internal state.
- R10: Addresses 0x0 to 0x3 select channels A to D. Channel n drives `code_o[16n+15:16n]` and `ch_en_o[n]`. Address 0xF selects all four channels. Commands 0x0 to 0x4 that carry a reserved address (0x4 to 0xE) are ignored completely.
- R11: Commands 0x1 and 0x4 to 0x7 do not depend on `data_i`.
- R12: With `RES_BITS` = 12, the low 4 bits of every active code read as zero.
- R13: A command with `cmd_valid_i` high at a rising clock edge shows its effect on the outputs right after that same edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_mid_i | input | 1 | Reset code select: 0 = zero-scale, 1 = mid-scale |
| cmd_valid_i | input | 1 | One-cycle qualifier for cmd_i, addr_i and data_i |
| cmd_i | input | 4 | Command code |
| addr_i | input | 4 | Channel address |
| data_i | input | 16 | Data word |
| code_o | output | 64 | Active codes; channel n in bits 16n+15:16n |
| ch_en_o | output | 4 | Per-channel enable; 0 = powered down |
| ref_en_o | output | 1 | Internal reference enable |

## Verification
The bench issues random commands across all sixteen codes. Addresses are drawn from the valid channels, the all-channels code and the reserved range. This separates the per-channel paths from the broadcast path and from the ignored cases. Directed sequences follow:
- Load a staging register without updating it, then update it. This shows whether write and update are really held apart.
- Power a channel down and then update it with different data on the bus. This shows that power-down keeps the register contents and that a non-writing command does not use the data word.
- Run reset with both strap levels. This tells the zero-scale start-up from the mid-scale one.
- Drive a 12-bit instance from the same stimulus. This exposes any low bits that are not cleared.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

  typedef enum logic [3:0] {
    OP_WRITE         = 4'h0,
    OP_UPDATE        = 4'h1,
    OP_WRITE_UPD_ALL = 4'h2,
    OP_WRITE_UPD     = 4'h3,
    OP_PD_CH         = 4'h4,
    OP_PD_CHIP       = 4'h5,
    OP_REF_INT       = 4'h6,
    OP_REF_EXT       = 4'h7,
    OP_NOP           = 4'hF
  } op_e;

  localparam logic [3:0] ADDR_ALL = 4'hF;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [3:0]        cmd_i,
  input  logic [3:0]        addr_i,
  output logic [NUM_CH-1:0] wr_o,
  output logic [NUM_CH-1:0] upd_o,
  output logic [NUM_CH-1:0] pd_o,
  output logic              ref_on_o,
  output logic              ref_off_o
);

  logic [NUM_CH-1:0] hit;
  logic              addr_ok;
  logic              is_all;

  assign is_all  = (addr_i == ADDR_ALL);
  assign addr_ok = is_all || (int'(addr_i) < NUM_CH);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign hit[i] = is_all || (addr_i == 4'(i));
  end

  always_comb begin
    wr_o      = '0;
    upd_o     = '0;
    pd_o      = '0;
    ref_on_o  = 1'b0;
    ref_off_o = 1'b0;
    if (valid_i) begin
      case (cmd_i)
        OP_WRITE: if (addr_ok) wr_o = hit;
        OP_UPDATE: if (addr_ok) upd_o = hit;
        OP_WRITE_UPD_ALL: if (addr_ok) begin
          wr_o  = hit;
          upd_o = '1;
        end
        OP_WRITE_UPD: if (addr_ok) begin
          wr_o  = hit;
          upd_o = hit;
        end
        OP_PD_CH: if (addr_ok) pd_o = hit;
        OP_PD_CHIP: begin
          pd_o      = '1;
          ref_off_o = 1'b1;
        end
        OP_REF_INT: ref_on_o  = 1'b1;
        OP_REF_EXT: ref_off_o = 1'b1;
        default: ;
      endcase
    end
  end

  // R10
  reserved_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !is_all && int'(addr_i) >= NUM_CH) |-> ((wr_o | upd_o) == '0));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |-> ((wr_o | upd_o | pd_o) == '0 && !ref_on_o && !ref_off_o));

endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int CODE_W   = 16,
  parameter int RES_BITS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_mid_i,
  input  logic              wr_i,
  input  logic              upd_i,
  input  logic              pd_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              en_o
);

  localparam int              PAD  = CODE_W - RES_BITS;
  localparam logic [CODE_W-1:0] ONES = '1;
  localparam logic [CODE_W-1:0] KEEP = ONES << PAD;
  localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] act_q;
  logic              en_q;
  logic [CODE_W-1:0] stage_nx;

  assign stage_nx = wr_i ? data_i : stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= rst_mid_i ? MID : '0;
      act_q   <= rst_mid_i ? (MID & KEEP) : '0;
      en_q    <= 1'b1;
    end else begin
      stage_q <= stage_nx;
      if (upd_i) act_q <= stage_nx & KEEP;
      if (upd_i) en_q <= 1'b1;
      else if (pd_i) en_q <= 1'b0;
    end
  end

  assign code_o = act_q;
  assign en_o   = en_q;

  // R6
  pd_keeps_code_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_i && !upd_i) |=> ($stable(code_o) && !en_o));

  // R3
  upd_enables_chk: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> en_o);

  // R2
  no_upd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(code_o));

  // R12
  low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (code_o & ~KEEP) == '0);

endmodule

// File: rtl/dac_ref_ctl.sv
module dac_ref_ctl (
  input  logic clk,
  input  logic rst,
  input  logic on_i,
  input  logic off_i,
  output logic en_o
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b1;
    else if (on_i)  en_q <= 1'b1;
    else if (off_i) en_q <= 1'b0;
  end

  assign en_o = en_q;

  // R8
  ref_off_chk: assert property (@(posedge clk) disable iff (rst)
    (off_i && !on_i) |=> !en_o);

  // R8
  ref_on_chk: assert property (@(posedge clk) disable iff (rst)
    on_i |=> en_o);

endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CODE_W   = 16,
  parameter int RES_BITS = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     por_mid_i,
  input  logic                     cmd_valid_i,
  input  logic [3:0]               cmd_i,
  input  logic [3:0]               addr_i,
  input  logic [CODE_W-1:0]        data_i,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        ch_en_o,
  output logic                     ref_en_o
);

  logic [NUM_CH-1:0] wr_sel;
  logic [NUM_CH-1:0] upd_sel;
  logic [NUM_CH-1:0] pd_sel;
  logic              ref_on;
  logic              ref_off;

  dac_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .clk(clk), .rst(rst), .valid_i(cmd_valid_i), .cmd_i(cmd_i), .addr_i(addr_i),
    .wr_o(wr_sel), .upd_o(upd_sel), .pd_o(pd_sel),
    .ref_on_o(ref_on), .ref_off_o(ref_off)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dac_chan #(.CODE_W(CODE_W), .RES_BITS(RES_BITS)) u_ch (
      .clk(clk), .rst(rst), .rst_mid_i(por_mid_i),
      .wr_i(wr_sel[i]), .upd_i(upd_sel[i]), .pd_i(pd_sel[i]),
      .data_i(data_i),
      .code_o(code_o[i*CODE_W +: CODE_W]), .en_o(ch_en_o[i])
    );
  end

  dac_ref_ctl u_ref (
    .clk(clk), .rst(rst), .on_i(ref_on), .off_i(ref_off), .en_o(ref_en_o)
  );

  // R9
  reserved_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && (cmd_i == OP_NOP || cmd_i[3])) |=>
      ($stable(code_o) && $stable(ch_en_o) && $stable(ref_en_o)));

  // R7
  chip_pd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_i == OP_PD_CHIP) |=>
      (ch_en_o == '0 && !ref_en_o && $stable(code_o)));

endmodule

// File: tb/sim_quad_dac_ctrl.sv
module sim_quad_dac_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por_mid = 1'b0;
  logic        vld = 1'b0;
  logic [3:0]  cmd = 4'hF;
  logic [3:0]  addr = 4'h0;
  logic [15:0] data = 16'h0;
  logic [63:0] code0, code1;
  logic [3:0]  en0, en1;
  logic        ref0, ref1;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_in [4];
  logic [15:0] m_act [4];
  logic [3:0]  m_en;
  logic        m_ref;

  always #10 clk = ~clk;

  quad_dac_ctrl u0 (
    .clk(clk), .rst(rst), .por_mid_i(por_mid), .cmd_valid_i(vld), .cmd_i(cmd),
    .addr_i(addr), .data_i(data), .code_o(code0), .ch_en_o(en0), .ref_en_o(ref0)
  );

  quad_dac_ctrl #(.RES_BITS(12)) u1 (
    .clk(clk), .rst(rst), .por_mid_i(por_mid), .cmd_valid_i(vld), .cmd_i(cmd),
    .addr_i(addr), .data_i(data), .code_o(code1), .ch_en_o(en1), .ref_en_o(ref1)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 4; i++) begin
      chk(req, $sformatf("code ch%0d", i), 32'(code0[i*16 +: 16]), 32'(m_act[i]));
      chk({req, " R12"}, $sformatf("12b code ch%0d", i), 32'(code1[i*16 +: 16]),
          32'(m_act[i] & 16'hFFF0));
    end
    chk(req, "enables", 32'(en0), 32'(m_en));
    chk(req, "ref", 32'(ref0), 32'(m_ref));
  endtask

  function automatic string tag_of(logic [3:0] c, logic [3:0] a);
    if (c inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4} && !(a < 4 || a == 4'hF)) return "R10";
    case (c)
      4'h0: return "R2";
      4'h1: return "R3";
      4'h2: return "R4";
      4'h3: return "R5";
      4'h4: return "R6";
      4'h5: return "R7";
      4'h6, 4'h7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset(logic mid);
    for (int i = 0; i < 4; i++) begin
      m_in[i]  = mid ? 16'h8000 : 16'h0000;
      m_act[i] = m_in[i];
    end
    m_en  = 4'hF;
    m_ref = 1'b1;
  endtask

  task automatic model_apply(logic [3:0] c, logic [3:0] a, logic [15:0] d);
    logic [3:0] sel;
    bit ok;
    ok  = (a < 4) || (a == 4'hF);
    sel = (a == 4'hF) ? 4'hF : (a < 4 ? (4'b0001 << a) : 4'h0);
    if (c == 4'h5) begin
      m_en = 4'h0; m_ref = 1'b0;
    end else if (c == 4'h6) m_ref = 1'b1;
    else if (c == 4'h7) m_ref = 1'b0;
    else if (ok && c <= 4'h4) begin
      for (int i = 0; i < 4; i++) begin
        if (sel[i] && (c == 4'h0 || c == 4'h2 || c == 4'h3)) m_in[i] = d;
      end
      for (int i = 0; i < 4; i++) begin
        if ((c == 4'h2) || (sel[i] && (c == 4'h1 || c == 4'h3))) begin
          m_act[i] = m_in[i]; m_en[i] = 1'b1;
        end
        if (sel[i] && c == 4'h4) m_en[i] = 1'b0;
      end
    end
  endtask

  task automatic issue(logic [3:0] c, logic [3:0] a, logic [15:0] d, string req);
    @(negedge clk);
    vld = 1'b1; cmd = c; addr = a; data = d;
    @(negedge clk);
    vld = 1'b0; data = $urandom();
    model_apply(c, a, d);
    check_all(req);
  endtask

  task automatic do_reset(logic mid);
    @(negedge clk);
    rst = 1'b1; por_mid = mid;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset(mid);
    check_all("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset(1'b0);
    do_reset(1'b1);

    // R2 / R3: staging load stays hidden until the update
    issue(4'h0, 4'h2, 16'hBEEF, "R2");
    issue(4'h1, 4'h2, 16'h1234, "R3 R11");

    // R13: outputs unchanged before the edge, changed right after it
    @(negedge clk);
    vld = 1'b1; cmd = 4'h3; addr = 4'h1; data = 16'hA5A7;
    #5 chk("R13", "before edge", 32'(code0[31:16]), 32'(m_act[1]));
    @(negedge clk);
    vld = 1'b0;
    model_apply(4'h3, 4'h1, 16'hA5A7);
    check_all("R13 R5");

    // R6 / R11: power-down keeps contents, update restores staged value
    issue(4'h4, 4'h1, 16'hFFFF, "R6 R11");
    issue(4'h1, 4'h1, 16'h0000, "R6 R11");

    // R10: reserved addresses ignored, broadcast address hits all
    issue(4'h3, 4'h7, 16'h7777, "R10");
    issue(4'h4, 4'hE, 16'h0, "R10");
    issue(4'h0, 4'hF, 16'h3C3F, "R10");
    issue(4'h1, 4'hF, 16'h0, "R10");

    // R4: write one and update all
    issue(4'h0, 4'h0, 16'h1111, "R4");
    issue(4'h4, 4'h3, 16'h0, "R4");
    issue(4'h2, 4'h3, 16'h9999, "R4");

    // R7 / R8 / R9
    issue(4'h5, 4'h0, 16'hDEAD, "R7");
    issue(4'h6, 4'h9, 16'h0, "R8");
    issue(4'h7, 4'h0, 16'h0, "R8");
    issue(4'hF, 4'h0, 16'h4321, "R9");
    issue(4'h9, 4'h1, 16'h4321, "R9");

    // R12: odd low bits
    issue(4'h3, 4'h0, 16'hFFFF, "R12");

    for (int n = 0; n < 600; n++) begin
      logic [3:0] c, a;
      int r;
      c = 4'($urandom_range(0, 15));
      r = $urandom_range(0, 9);
      if (r < 4) a = 4'(r);
      else if (r < 6) a = 4'hF;
      else a = 4'($urandom_range(4, 14));
      issue(c, a, 16'($urandom()), tag_of(c, a));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule